// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt lines and turns the activity on them into interrupt requests for a processor. Each line first passes through a synchroniser. A per-line detector then looks for the edge or level condition that software has chosen. A detected condition sets a pending bit. The pending bit stays set until software clears it through the source register, except in the level modes, where an active level sets it again on every cycle. A pending line raises a request only if its mask bit is clear and its priority field is nonzero.

Software reaches the block through a plain register port: a write strobe, a 3-bit register index, 32-bit write data and a combinational read-data bus. There are six registers: sense, priority, source, mask-set, mask-clear and mode. Line bits are numbered from the most significant end. In a register of width W, line n owns bit W−1−n, so line 0 sits in the top bit. One bit in the mode register chooses how requests are delivered:

- **Individual mode:** one output per line.
- **Combined mode:** a single line that is the OR of every request.

Top module: `ext_irq_pin_ctrl`

## Requirements
- R1: After reset, every sense and priority field is 0, every pending bit is 0 and every line is masked. Both interrupt outputs are low, and the sense, priority, source and mode registers read 0.
- R2: Line n uses bit SRC_W−1−n of the source, mask-set and mask-clear registers. Its sense field starts at bit 32−(n+1)·SENSE_W, and its 4-bit priority field starts at bit 32−(n+1)·4. Register index 0 is sense, 1 is priority, 2 is source, 3 is mask-set, 4 is mask-clear and 5 is mode.
- R3: Sense code 0 sets pending on a falling edge and code 1 sets it on a rising edge. The pending bit becomes readable at most three clock edges after the line settles.
- R4: Code 2 (low level) and code 3 (high level) set pending on every cycle the level holds. Clearing the bit while the level persists has no lasting effect, and the bit stays clear once the level has gone.
- R5: Code 4 sets pending on either edge. Codes 5 to 15 detect nothing.
- R6: A write to the source register clears each pending bit written as 0 and leaves each bit written as 1 unchanged.
- R7: Writing 1 to a mask-set bit masks that line, and writing 1 to a mask-clear bit unmasks it. Bits written as 0 have no effect in either register.
- R8: A line whose priority field is 0 raises no request. Any nonzero field enables the line.
- R9: A line's request is the AND of three conditions: it is pending, it is unmasked and its priority is nonzero. The behaviour of the outputs depends on mode bit 23:
  - When bit 23 is 1, `irq_pin_o[n]` carries line n's request and `irq_any_o` is 0.
  - When bit 23 is 0, `irq_any_o` is the OR of all requests and `irq_pin_o` is 0.
- R10: Only bit 23 of the mode register is stored. The mask-set and mask-clear registers always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | NPINS | External interrupt lines |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_pin_o | output | NPINS | Per-line requests (individual mode) |
| irq_any_o | output | 1 | Combined request (combined mode) |

## Verification
A vector table drives each detector through every start/end level pair that matters. The pairs are:
- a matching edge against the opposite edge;
- a level that holds against a level that goes away;
- both-edges mode with a rise, with a fall and with no change;
- an undefined code.

Two reads follow every transition. The first, taken before a clear, tells an edge from a stale level. The second, taken after a clear, shows whether the condition is still present, which separates the latched edge modes from the retriggering level modes. Directed sequences then exercise the gating:
- one pending line walked through each mask, priority and mode combination;
- selective clears over two pending lines;
- masked writes in which zero bits must leave other lines alone.

// File: rtl/eip_pkg.sv
package eip_pkg;

    typedef enum logic [3:0] {
        SNS_FALL = 4'd0,
        SNS_RISE = 4'd1,
        SNS_LOW  = 4'd2,
        SNS_HIGH = 4'd3,
        SNS_BOTH = 4'd4
    } sense_e;

    typedef enum logic [2:0] {
        REG_SENSE = 3'd0,
        REG_PRIO  = 3'd1,
        REG_SRC   = 3'd2,
        REG_MSET  = 3'd3,
        REG_MCLR  = 3'd4,
        REG_MODE  = 3'd5
    } reg_e;

    localparam int DATA_W   = 32;
    localparam int PRIO_W   = 4;
    localparam int MODE_BIT = 23;

endpackage

// File: rtl/eip_sync.sv
module eip_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= d_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/eip_detect.sv
module eip_detect
    import eip_pkg::*;
(
    input  logic       cur_i,
    input  logic       prev_i,
    input  logic [3:0] code_i,
    output logic       evt_o
);
    always_comb begin
        evt_o = 1'b0;
        unique case (sense_e'(code_i))
            SNS_FALL: evt_o = prev_i & ~cur_i;
            SNS_RISE: evt_o = ~prev_i & cur_i;
            SNS_LOW:  evt_o = ~cur_i;
            SNS_HIGH: evt_o = cur_i;
            SNS_BOTH: evt_o = prev_i ^ cur_i;
            default:  evt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ext_irq_pin_ctrl.sv
module ext_irq_pin_ctrl
    import eip_pkg::*;
#(
    parameter int NPINS   = 8,
    parameter int SENSE_W = 4,
    parameter int SRC_W   = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [NPINS-1:0]  irq_pin_o,
    output logic              irq_any_o
);
    logic [NPINS-1:0]  pin_cur;
    logic [NPINS-1:0]  pin_prev;
    logic [NPINS-1:0]  evt;
    logic [NPINS-1:0]  req;
    logic [NPINS-1:0]  wsel;
    logic [NPINS-1:0]  pend_q;
    logic [NPINS-1:0]  msk_q;
    logic [DATA_W-1:0] sense_q;
    logic [DATA_W-1:0] prio_q;
    logic              mode_q;
    logic [SRC_W-1:0]  src_rd;
    reg_e              sel;

    assign sel = reg_e'(addr_i);

    eip_sync #(.W(NPINS)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        localparam int SOFF = DATA_W - (n + 1) * SENSE_W;
        localparam int POFF = DATA_W - (n + 1) * PRIO_W;
        logic [3:0] code;
        if (SENSE_W == 4) begin : g_w4
            assign code = sense_q[SOFF +: 4];
        end else begin : g_w2
            assign code = {2'b00, sense_q[SOFF +: 2]};
        end
        eip_detect u_det (
            .cur_i  (pin_cur[n]),
            .prev_i (pin_prev[n]),
            .code_i (code),
            .evt_o  (evt[n])
        );
        assign wsel[n] = wdata_i[SRC_W-1-n];
        assign req[n]  = pend_q[n] & ~msk_q[n] & (|prio_q[POFF +: PRIO_W]);
    end

    // configuration registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sense_q <= '0;
            prio_q  <= '0;
            mode_q  <= 1'b0;
        end else if (wr_en_i) begin
            if (sel == REG_SENSE) sense_q <= wdata_i;
            if (sel == REG_PRIO)  prio_q  <= wdata_i;
            if (sel == REG_MODE)  mode_q  <= wdata_i[MODE_BIT];
        end
    end

    // mask state: set and clear through separate indices
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            msk_q <= '1;
        end else if (wr_en_i && sel == REG_MSET) begin
            msk_q <= msk_q | wsel;
        end else if (wr_en_i && sel == REG_MCLR) begin
            msk_q <= msk_q & ~wsel;
        end
    end

    // pending latch: a new event wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= '0;
        end else if (wr_en_i && sel == REG_SRC) begin
            pend_q <= (pend_q & wsel) | evt;
        end else begin
            pend_q <= pend_q | evt;
        end
    end

    always_comb begin
        src_rd = '0;
        for (int n = 0; n < NPINS; n++) src_rd[SRC_W-1-n] = pend_q[n];
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_SENSE: rdata_o = sense_q;
            REG_PRIO:  rdata_o = prio_q;
            REG_SRC:   rdata_o = 32'(src_rd);
            REG_MODE:  rdata_o = 32'(mode_q) << MODE_BIT;
            default:   rdata_o = '0;
        endcase
    end

    assign irq_pin_o = mode_q ? req : '0;
    assign irq_any_o = ~mode_q & (|req);
endmodule

// File: rtl/eip_ctrl_chk.sv
module eip_ctrl_chk
    import eip_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int SRC_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [2:0]       addr_i,
    input logic [31:0]      wdata_i,
    input logic [NPINS-1:0] pend_i,
    input logic [NPINS-1:0] msk_i,
    input logic [NPINS-1:0] irq_pin_i,
    input logic             irq_any_i
);
    logic [NPINS-1:0] bits;

    always_comb begin
        for (int n = 0; n < NPINS; n++) bits[n] = wdata_i[SRC_W-1-n];
    end

    a_r1_masked_out_of_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (&msk_i && pend_i == '0));

    a_r7_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'(REG_MSET)) |=> ((msk_i & $past(bits)) == $past(bits)));

    a_r7_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 3'(REG_MCLR)) |=> ((msk_i & $past(bits)) == '0));

    a_r9_pin_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_pin_i & (~pend_i | msk_i)) == '0);

    a_r9_any_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_any_i |-> (|(pend_i & ~msk_i)));

    a_r9_one_style: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq_any_i && (|irq_pin_i)));
endmodule

bind ext_irq_pin_ctrl eip_ctrl_chk #(.NPINS(NPINS), .SRC_W(SRC_W)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .pend_i    (pend_q),
    .msk_i     (msk_q),
    .irq_pin_i (irq_pin_o),
    .irq_any_i (irq_any_o)
);

// File: tb/ext_irq_pin_ctrl_tb.sv
module ext_irq_pin_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic        wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq_pin;
    logic        irq_any;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_pin_ctrl #(.NPINS(NP), .SENSE_W(4), .SRC_W(8)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_en_i(wr), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_pin_o(irq_pin), .irq_any_o(irq_any)
    );

    // {pin[2:0], code[3:0], start, end, read1, read2}
    localparam logic [10:0] VEC [13] = '{
        {3'd0, 4'd0, 1'b1, 1'b0, 1'b1, 1'b0},   // R3 falling seen
        {3'd1, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0},   // R3 rise ignored
        {3'd2, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0},   // R3 rising seen
        {3'd3, 4'd1, 1'b1, 1'b0, 1'b0, 1'b0},   // R3 fall ignored
        {3'd4, 4'd2, 1'b1, 1'b0, 1'b1, 1'b1},   // R4 low appears
        {3'd5, 4'd2, 1'b0, 1'b1, 1'b1, 1'b0},   // R4 low goes away
        {3'd6, 4'd3, 1'b0, 1'b1, 1'b1, 1'b1},   // R4 high appears
        {3'd7, 4'd3, 1'b1, 1'b0, 1'b1, 1'b0},   // R4 high goes away
        {3'd0, 4'd4, 1'b0, 1'b1, 1'b1, 1'b0},   // R5 both, rise
        {3'd1, 4'd4, 1'b1, 1'b0, 1'b1, 1'b0},   // R5 both, fall
        {3'd2, 4'd4, 1'b0, 1'b0, 1'b0, 1'b0},   // R5 both, no change
        {3'd3, 4'd5, 1'b1, 1'b0, 1'b0, 1'b0},   // R5 undefined code
        {3'd4, 4'd2, 1'b0, 1'b0, 1'b1, 1'b1}    // R4 clear while level held
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        wr = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic out_chk(input string req, input logic [7:0] ep, input logic ea);
        @(negedge clk);
        #1;
        chk(req, {24'd0, irq_pin}, {24'd0, ep});
        chk(req, {31'd0, irq_any}, {31'd0, ea});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rv;
        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, R10 write-only reads
        for (int r = 0; r < 6; r++) begin
            bus_rd(3'(r), rv);
            chk("R1/R10 reset readback", rv, 32'd0);
        end
        out_chk("R1 outputs quiet", 8'h00, 1'b0);

        // vector table
        for (int v = 0; v < 13; v++) begin
            int p;
            logic [31:0] sw;
            p = int'(VEC[v][10:8]);
            sw = 32'(VEC[v][7:4]) << (32 - (p + 1) * 4);
            bus_wr(3'd0, sw);
            @(negedge clk) pins[p] = VEC[v][3];
            idle(5);
            bus_wr(3'd2, 32'd0);
            pins[p] = VEC[v][2];
            idle(5);
            bus_rd(3'd2, rv);
            chk("R3/R4/R5 read1", {31'd0, rv[7-p]}, {31'd0, VEC[v][1]});
            bus_wr(3'd2, 32'd0);
            idle(5);
            bus_rd(3'd2, rv);
            chk("R3/R4/R5 read2", {31'd0, rv[7-p]}, {31'd0, VEC[v][0]});
        end

        // R2 mapping: only line 6 at high level, everything else inert code 7
        @(negedge clk) pins = 8'h40;
        bus_wr(3'd0, 32'h7777_7737);
        bus_rd(3'd0, rv);
        chk("R2 sense readback", rv, 32'h7777_7737);
        idle(5);
        bus_wr(3'd2, 32'd0);
        idle(2);
        bus_rd(3'd2, rv);
        chk("R2 line 6 at source bit 1", rv, 32'h0000_0002);

        // R7/R8/R9 gating
        out_chk("R9 masked line quiet", 8'h00, 1'b0);
        bus_wr(3'd4, 32'h02);
        out_chk("R8 zero priority blocks", 8'h00, 1'b0);
        bus_wr(3'd1, 32'h0000_00F0);
        bus_rd(3'd1, rv);
        chk("R2 priority readback", rv, 32'h0000_00F0);
        out_chk("R9 combined mode", 8'h00, 1'b1);
        bus_wr(3'd5, 32'hFFFF_FFFF);
        bus_rd(3'd5, rv);
        chk("R10 mode stores bit 23 only", rv, 32'h0080_0000);
        out_chk("R9 individual mode", 8'h40, 1'b0);
        bus_wr(3'd3, 32'h02);
        out_chk("R7 mask set", 8'h00, 1'b0);
        bus_wr(3'd4, 32'hFD);
        out_chk("R7 zero bits in clear ignored", 8'h00, 1'b0);
        bus_wr(3'd4, 32'h02);
        out_chk("R7 mask clear", 8'h40, 1'b0);
        bus_wr(3'd3, 32'hFD);
        out_chk("R7 zero bits in set ignored", 8'h40, 1'b0);
        bus_wr(3'd1, 32'hFFFF_FF0F);
        out_chk("R8 other fields do not enable", 8'h00, 1'b0);
        bus_wr(3'd1, 32'h0000_0010);
        out_chk("R8 any nonzero value enables", 8'h40, 1'b0);
        bus_rd(3'd3, rv);
        chk("R10 mask-set reads 0", rv, 32'd0);
        bus_rd(3'd4, rv);
        chk("R10 mask-clear reads 0", rv, 32'd0);

        // R6 selective clear with two rising edges on lines 0 and 3
        @(negedge clk) pins = 8'h00;
        bus_wr(3'd0, 32'h1111_1111);
        idle(5);
        bus_wr(3'd2, 32'd0);
        @(negedge clk) pins = 8'h09;
        idle(5);
        bus_rd(3'd2, rv);
        chk("R6 two pending", rv, 32'h0000_0090);
        bus_wr(3'd2, 32'h0000_00EF);
        bus_rd(3'd2, rv);
        chk("R6 clear only zero bits", rv, 32'h0000_0080);
        bus_wr(3'd2, 32'd0);
        bus_rd(3'd2, rv);
        chk("R6 clear all", rv, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule